// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver

This block receives asynchronous serial frames on a single line and turns each one into a data byte. The line is idle high. A frame opens with a low start bit, then carries eight data bits least significant bit first, one parity bit and one high stop bit. The block runs from a 50 MHz clock and targets 115200 baud. It divides the clock by 27 to make an oversampling tick at about sixteen times the bit rate.

A falling edge on the synchronized line starts reception. From that edge a single frame counter advances once per tick over the whole frame, sixteen counts per bit. Bit N is sampled at the tick where the counter steps to 16*N+8, which is the middle of that bit. The tick is a whole number of clocks, so the sampling point drifts slightly against a true 115200 baud sender. The drift stays near 0.5 percent and well inside half a bit over the eleven-bit frame.

The state machine has five states. IDLE waits for a falling edge and then goes to START. START goes back to IDLE (glitch reject) when the start bit reads high at its mid-point, and goes to DATA when it reads low. DATA goes to PARITY after the eighth data sample. PARITY goes to STOP after the parity sample. STOP goes to IDLE after the stop sample and reports either a good byte or a framing error. The frame counter is brought out for debug.

Top module: `uart_ovs_rx`

## Requirements
- R1: After reset the valid strobe, parity-error flag and framing-error flag are 0, the data output is 8'h00 and the frame counter output is 0.
- R2: A frame whose stop bit is high yields a valid strobe exactly one clock wide. During that strobe the data output equals the eight data bits, with the first bit received on the line in bit 0.
- R3: With the default parity setting (even), the parity-error flag is 1 during the valid strobe exactly when the total number of ones in the data bits plus the parity bit is odd, and 0 otherwise. Outside the strobe it is 0.
- R4: A frame whose stop bit samples low gives a one-clock framing-error pulse and no valid strobe.
- R5: A low pulse on the line shorter than half a bit makes the start bit sample high. The receiver then returns to IDLE with no valid strobe and no framing error, and the frame counter output is back at 0.
- R6: Each bit is sampled where the frame counter steps to 16*N+8, counted in ticks of 27 clocks from the detected falling edge. Frames whose bit period is 430, 432 or 434 clocks are received correctly.
- R7: During the valid strobe the frame counter output reads 168, which is the stop-bit sampling value. One clock later it reads 0.
- R8: A new start bit that follows the stop bit directly, with no idle time, is received as a separate frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz nominal |
| rst | input | 1 | Synchronous reset, active high |
| rxd_i | input | 1 | Asynchronous serial receive line, idle high |
| rx_data_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-clock strobe marking a good frame |
| par_err_o | output | 1 | Parity mismatch, meaningful with rx_valid_o |
| frm_err_o | output | 1 | One-clock pulse when the stop bit is low |
| dbg_cnt_o | output | 8 | Frame counter, in ticks since the start edge |

## Verification
If the state or the frame counter goes wrong, the error appears at the ports within one frame. A misplaced sampling point shows up as a byte shifted by one bit or as a false framing error. A counter that does not clear shows up as a nonzero debug count one clock after the strobe, or as a missed next frame when frames arrive back to back. A wrong parity accumulator shows up as a flipped error flag during the strobe of that same frame. A start-bit glitch that is not rejected shows up as a spurious strobe or framing pulse about ten bit times later.

// File: rtl/uart_ovs_rx_pkg.sv
package uart_ovs_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/urx_sync.sv
module urx_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic line_o,
    output logic fall_o
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign line_o = sync_q;
    assign fall_o = prev_q & ~sync_q;
endmodule

// File: rtl/urx_tick_gen.sv
module urx_tick_gen #(
    parameter int CLK_DIV = 27
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            div_q <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick_o = run_i && (div_q == DIV_LAST);

    // R6: ticks are at least two clocks apart
    a_r6_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
endmodule

// File: rtl/urx_shift.sv
module urx_shift #(
    parameter int DATA_W     = 8,
    parameter bit PARITY_ODD = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              bit_i,
    input  logic              shift_en_i,
    input  logic              par_en_i,
    output logic [DATA_W-1:0] data_o,
    output logic              par_bad_o
);
    logic [DATA_W-1:0] sh_q;
    logic              acc_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            sh_q  <= '0;
            acc_q <= 1'b0;
        end else begin
            if (shift_en_i) begin
                sh_q <= {bit_i, sh_q[DATA_W-1:1]};
            end
            if (par_en_i) begin
                acc_q <= acc_q ^ bit_i;
            end
        end
    end

    assign data_o    = sh_q;
    assign par_bad_o = acc_q ^ PARITY_ODD;
endmodule

// File: rtl/uart_ovs_rx.sv
module uart_ovs_rx
    import uart_ovs_rx_pkg::*;
#(
    parameter int CLK_DIV    = 27,
    parameter int OVS        = 16,
    parameter int DATA_W     = 8,
    parameter bit PARITY_ODD = 1'b0,
    localparam int FRAME_BITS = DATA_W + 3,
    localparam int CNT_W      = $clog2(FRAME_BITS * OVS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    output logic              par_err_o,
    output logic              frm_err_o,
    output logic [CNT_W-1:0]  dbg_cnt_o
);
    localparam int OVS_W = $clog2(OVS);
    localparam int IDX_W = CNT_W - OVS_W;
    localparam logic [OVS_W-1:0] PRE_MID  = OVS_W'(OVS / 2 - 1);
    localparam logic [IDX_W-1:0] LAST_DAT = IDX_W'(DATA_W);

    rx_state_e         state_q, state_d;
    logic              line, fall, tick, samp;
    logic [CNT_W-1:0]  frm_cnt_q;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] sh_data;
    logic              par_bad;

    urx_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (rxd_i),
        .line_o  (line),
        .fall_o  (fall)
    );

    urx_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run_i  (state_q != RX_IDLE),
        .tick_o (tick)
    );

    urx_shift #(.DATA_W(DATA_W), .PARITY_ODD(PARITY_ODD)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (state_q == RX_IDLE),
        .bit_i      (line),
        .shift_en_i (samp && state_q == RX_DATA),
        .par_en_i   (samp && (state_q == RX_DATA || state_q == RX_PARITY)),
        .data_o     (sh_data),
        .par_bad_o  (par_bad)
    );

    // frame-wide counter: one count per tick, cleared while idle
    always_ff @(posedge clk) begin
        if (rst || state_q == RX_IDLE) begin
            frm_cnt_q <= '0;
        end else if (tick) begin
            frm_cnt_q <= frm_cnt_q + 1'b1;
        end
    end

    assign bit_idx = frm_cnt_q[CNT_W-1:OVS_W];
    assign samp    = tick && (frm_cnt_q[OVS_W-1:0] == PRE_MID);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (fall) state_d = RX_START;
            RX_START:  if (samp) state_d = line ? RX_IDLE : RX_DATA;
            RX_DATA:   if (samp && bit_idx == LAST_DAT) state_d = RX_PARITY;
            RX_PARITY: if (samp) state_d = RX_STOP;
            RX_STOP:   if (samp) state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data_o  <= '0;
            rx_valid_o <= 1'b0;
            par_err_o  <= 1'b0;
            frm_err_o  <= 1'b0;
        end else begin
            rx_valid_o <= 1'b0;
            par_err_o  <= 1'b0;
            frm_err_o  <= 1'b0;
            if (state_q == RX_STOP && samp) begin
                if (line) begin
                    rx_valid_o <= 1'b1;
                    rx_data_o  <= sh_data;
                    par_err_o  <= par_bad;
                end else begin
                    frm_err_o  <= 1'b1;
                end
            end
        end
    end

    assign dbg_cnt_o = frm_cnt_q;

    // R2: strobe lasts one clock
    a_r2_valid_one_clk: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);
    // R4: framing error and good byte never together
    a_r4_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid_o && frm_err_o));
    // R3: parity flag only alongside the strobe
    a_r3_perr_with_valid: assert property (@(posedge clk) disable iff (rst)
        par_err_o |-> rx_valid_o);
    // R7: counter clears right after the strobe
    a_r7_cnt_clears: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> frm_cnt_q == '0);
    // R6: counter advances by one per tick during a frame
    a_r6_cnt_step: assert property (@(posedge clk) disable iff (rst)
        (state_q != RX_IDLE && tick) |=> frm_cnt_q == CNT_W'($past(frm_cnt_q) + 1'b1));
    // R5: high start sample aborts the frame
    a_r5_glitch_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_START && samp && line) |=> state_q == RX_IDLE);
endmodule

// File: tb/tb_uart_ovs_rx.sv
module tb_uart_ovs_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid, par_err, frm_err;
    logic [7:0] dbg_cnt;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_ovs_rx dut (
        .clk        (clk),
        .rst        (rst),
        .rxd_i      (rxd),
        .rx_data_o  (rx_data),
        .rx_valid_o (rx_valid),
        .par_err_o  (par_err),
        .frm_err_o  (frm_err),
        .dbg_cnt_o  (dbg_cnt)
    );

    typedef struct packed {
        logic [7:0] d;
        logic       bad_par;
        logic       stop;
        logic [9:0] per;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{8'h11, 1'b0, 1'b1, 10'd434},
        '{8'hA5, 1'b0, 1'b1, 10'd432},
        '{8'h00, 1'b0, 1'b1, 10'd430},
        '{8'hFF, 1'b1, 1'b1, 10'd432},
        '{8'h80, 1'b0, 1'b1, 10'd434},
        '{8'h3C, 1'b1, 1'b1, 10'd430},
        '{8'h5A, 1'b0, 1'b0, 10'd432},
        '{8'h01, 1'b0, 1'b1, 10'd432}
    };

    // monitor
    int         vcount = 0;
    int         fcount = 0;
    logic [7:0] last_d, prev_d;
    logic       last_pe;
    logic [7:0] cnt_at_v, cnt_after_v;
    logic       after_pending = 1'b0;

    always @(negedge clk) begin
        if (after_pending) begin
            cnt_after_v   <= dbg_cnt;
            after_pending <= 1'b0;
        end
        if (rx_valid) begin
            vcount        <= vcount + 1;
            prev_d        <= last_d;
            last_d        <= rx_data;
            last_pe       <= par_err;
            cnt_at_v      <= dbg_cnt;
            after_pending <= 1'b1;
        end
        if (frm_err) fcount <= fcount + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic bad_par,
                              input logic stop, input int per);
        logic [10:0] bits;
        logic        p;
        p    = (^d) ^ bad_par;   // even parity unless flipped
        bits = {stop, p, d, 1'b0};
        for (int i = 0; i < 11; i++) begin
            @(negedge clk) rxd = bits[i];
            repeat (per - 1) @(negedge clk);
        end
        @(negedge clk) rxd = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v0, f0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
        check(frm_err == 1'b0, "R1 frm_err", frm_err, 0);
        check(par_err == 1'b0, "R1 par_err", par_err, 0);
        check(rx_data == 8'h00, "R1 data", rx_data, 0);
        check(dbg_cnt == 8'd0, "R1 dbg_cnt", dbg_cnt, 0);
        repeat (20) @(negedge clk);

        // vector table
        for (int k = 0; k < 8; k++) begin
            v0 = vcount;
            f0 = fcount;
            send_frame(VECS[k].d, VECS[k].bad_par, VECS[k].stop, int'(VECS[k].per));
            repeat (600) @(negedge clk);
            if (VECS[k].stop) begin
                check(vcount == v0 + 1, "R2 one strobe", vcount - v0, 1);
                check(last_d == VECS[k].d, "R2 R6 data", last_d, VECS[k].d);
                check(last_pe == VECS[k].bad_par, "R3 parity flag", last_pe, VECS[k].bad_par);
                check(cnt_at_v == 8'd168, "R7 cnt at strobe", cnt_at_v, 168);
                check(cnt_after_v == 8'd0, "R7 cnt after strobe", cnt_after_v, 0);
                check(fcount == f0, "R4 no frame error", fcount - f0, 0);
            end else begin
                check(fcount == f0 + 1, "R4 frame error", fcount - f0, 1);
                check(vcount == v0, "R4 no strobe", vcount - v0, 0);
            end
        end

        // R5 start glitch
        v0 = vcount;
        f0 = fcount;
        @(negedge clk) rxd = 1'b0;
        repeat (100) @(negedge clk);
        rxd = 1'b1;
        repeat (16 * 432) @(negedge clk);
        check(vcount == v0, "R5 glitch no strobe", vcount - v0, 0);
        check(fcount == f0, "R5 glitch no frame error", fcount - f0, 0);
        check(dbg_cnt == 8'd0, "R5 counter idle", dbg_cnt, 0);

        // R5 then a good frame
        send_frame(8'h96, 1'b0, 1'b1, 432);
        repeat (600) @(negedge clk);
        check(vcount == v0 + 1 && last_d == 8'h96, "R5 recovery", last_d, 8'h96);

        // R8 back to back
        v0 = vcount;
        send_frame(8'hC3, 1'b0, 1'b1, 434);
        send_frame(8'h3D, 1'b1, 1'b1, 434);
        repeat (600) @(negedge clk);
        check(vcount == v0 + 2, "R8 two strobes", vcount - v0, 2);
        check(prev_d == 8'hC3, "R8 first byte", prev_d, 8'hC3);
        check(last_d == 8'h3D, "R8 second byte", last_d, 8'h3D);
        check(last_pe == 1'b1, "R8 R3 second parity", last_pe, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule